// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller converts single read or write requests from on-chip logic into timed cycles on an external bus with an 8-bit data path. Its multiplexed mode reaches 24 address bits. The low address byte and the data byte share port A, the middle address byte shares port B, and the top address byte goes straight out on port C. Its non-multiplexed mode keeps port A for data only and holds 16 address bits on ports C and B for the whole cycle.

Each access runs through a fixed order of phases:

1. An address phase with the latch strobe active, lasting a configurable number of clocks.
2. One gap clock with the latch strobe inactive.
3. A strobe phase of configurable length, which an active-low wait input can stretch.
4. One turnaround clock, in which the acknowledge pulses.

The settings are captured when a request is accepted:

- the bus mode,
- the latch-strobe polarity,
- the function of the two byte pins,
- the phase lengths.

The bus clock output has its own setting, which takes effect at once. It can be off, run at the core clock rate, or run at half that rate.

Top module: `ebus_ctrl`

## Requirements
- R1: In multiplexed mode the address phase lasts `cfg_addr_clks`+1 clocks. During this phase ALE is active and the address is driven as follows: port A drives address[7:0] with `pa_oe`=1, port B drives address[15:8], and port C drives address[23:16]. Then follows exactly one gap clock in which ALE is inactive and ports A and B still drive the address.
- R2: In the multiplexed strobe phase port B is 0. On a write, port A drives the write data with `pa_oe`=1. On a read, `pa_oe`=0 and `pa_out` is 0. Port C holds address[23:16] from the address phase through the strobe phase.
- R3: ALE is active high when `cfg_ale_hi`=1 and active low when `cfg_ale_hi`=0. At every other time ALE sits at the inactive level, and while the controller is idle that level follows the live `cfg_ale_hi`.
- R4: `rd_n` is low only during the strobe phase of a read, and `wr_n` is low only during the strobe phase of a write. The two are never low together. With `wait_n` high, the strobe phase lasts `cfg_strb_clks`+1 clocks.
- R5: If `wait_n` is low on a strobe-phase clock, the phase is stretched. The phase ends after the first clock, at or beyond its minimum length, on which `wait_n` is high. Outside the strobe phase `wait_n` has no effect.
- R6: On a read, `pa_in` is captured on the last clock of the strobe phase and presented on `rd_data`. `ack` is high for exactly one clock, the turnaround clock that directly follows the strobe phase, for both reads and writes.
- R7: `req_rdy` is high only when the controller is idle. A request is accepted on a clock where `req` and `req_rdy` are both high. Requests presented while busy are ignored. The controller is ready again on the clock after the turnaround clock.
- R8: In non-multiplexed mode ALE stays inactive. Port C drives address[15:8] and port B drives address[7:0] for the whole address, gap and strobe span. On a write, port A drives the write data with `pa_oe`=1 over that span. On a read, `pa_oe`=0.
- R9: With `cfg_pin_be`=0, `pin_lo` repeats `wr_n`. With `cfg_pin_be`=1, `pin_lo` is a lower-byte enable, low from the first address clock through the last strobe clock. `pin_hi` is always 1, because the data path is 8 bits wide.
- R10: The bus clock setting `cfg_bclk_mode` selects the output as follows: 0 holds `bclk` low; 1 makes `bclk` follow the core clock; 2 or 3 makes `bclk` toggle on every rising core-clock edge.
- R11: After reset and whenever idle, `pa_oe`=0, `rd_n`=`wr_n`=1, `pin_lo`=`pin_hi`=1 and `pa_out`/`pb_out`/`pc_out`=0.
- R12: Changes to the mode, polarity, pin-function or length settings during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 8 | Write data |
| req_rdy | output | 1 | Controller idle, request can be taken |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read data |
| cfg_mux | input | 1 | 1 = multiplexed 24-bit mode, 0 = non-multiplexed |
| cfg_ale_hi | input | 1 | ALE active level |
| cfg_pin_be | input | 1 | Byte pins: 0 = write strobes, 1 = byte enables |
| cfg_addr_clks | input | 2 | Address phase length minus one |
| cfg_strb_clks | input | 3 | Minimum strobe phase length minus one |
| cfg_bclk_mode | input | 2 | Bus clock: 0 off, 1 full rate, 2/3 half rate |
| wait_n | input | 1 | Active-low wait, stretches the strobe phase |
| pa_in | input | 8 | Port A input data |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 1 | Port A output enable |
| pb_out | output | 8 | Port B output value |
| pc_out | output | 8 | Port C output value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| pin_lo | output | 1 | Low write strobe or lower byte enable |
| pin_hi | output | 1 | High write strobe or upper byte enable |
| bclk | output | 1 | Bus clock output |

## Verification
All pins are decoded from the phase register and a phase counter, so any fault in either shows up at the ports within the same clock. Examples are a phase that ends one clock early or late, or a stretch that ignores `wait_n`. Such a fault moves an ALE or strobe edge, or leaves port A enabled while the external device drives it. The bench compares every pin on every clock of every access. It supplies the valid read byte only on the last strobe clock, so capturing one clock early or late returns the wrong byte in the acknowledge clock. Settings are scrambled during each access, which exposes any path that reads the live settings in place of the copy captured at acceptance.

// File: rtl/ebus_pkg.sv
// Shared widths, phase encoding and captured configuration for the
// external bus controller. Assumes an 8-bit external data path.
package ebus_pkg;
    localparam int ACNT_W = 2;   // address phase length field width
    localparam int SCNT_W = 3;   // strobe phase length field width

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_GAP,
        PH_STRB,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic              mux;
        logic              ale_hi;
        logic              pin_be;
        logic [ACNT_W-1:0] addr_clks;
        logic [SCNT_W-1:0] strb_clks;
    } bus_cfg_t;
endpackage

// File: rtl/ebus_seq.sv
// Phase sequencer: accepts one request while idle, captures the request
// and configuration, then steps through address, gap, strobe (with wait
// stretch) and turnaround. Captures read data on the last strobe clock.
// Assumes wait_n is already synchronous to clk.
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  bus_cfg_t          cfg_i,
    input  logic              wait_n_i,
    input  logic [DATA_W-1:0] pa_in_i,
    output logic              req_rdy_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rd_data_o,
    output phase_e            phase_o,
    output bus_cfg_t          cfg_q_o,
    output logic              we_q_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] wdata_q_o
);
    localparam int CNT_W = (ACNT_W > SCNT_W) ? ACNT_W : SCNT_W;

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_q;
    logic [DATA_W-1:0] rd_q;
    bus_cfg_t          cfg_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Phase advance, request capture and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
            rd_q    <= '0;
            cfg_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (req_i) begin
                        cfg_q   <= cfg_i;
                        we_q    <= req_we_i;
                        addr_q  <= req_addr_i;
                        wdata_q <= req_wdata_i;
                        cnt_q   <= CNT_W'(cfg_i.addr_clks);
                        phase_q <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (cnt_q == '0) phase_q <= PH_GAP;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                PH_GAP: begin
                    cnt_q   <= CNT_W'(cfg_q.strb_clks);
                    phase_q <= PH_STRB;
                end
                PH_STRB: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (wait_n_i) begin
                        phase_q <= PH_TURN;
                        ack_q   <= 1'b1;
                        if (!we_q) rd_q <= pa_in_i;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign req_rdy_o = (phase_q == PH_IDLE);
    assign ack_o     = ack_q;
    assign rd_data_o = rd_q;
    assign phase_o   = phase_q;
    assign cfg_q_o   = cfg_q;
    assign we_q_o    = we_q;
    assign addr_q_o  = addr_q;
    assign wdata_q_o = wdata_q;

    AST_GAP_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_GAP) |-> ($past(phase_q) == PH_ADDR)); // R1
    AST_ADDR_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ADDR) |-> (cnt_q <= CNT_W'(cfg_q.addr_clks))); // R1
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STRB && cnt_q == '0 && !wait_n_i) |=> (phase_q == PH_STRB)); // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R6
    AST_TURN_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TURN) |-> ($past(phase_q) == PH_STRB)); // R7
endmodule

// File: rtl/ebus_pinmux.sv
// Pin decoder: from the current phase and the captured request and
// configuration, forms the port values, output enable, ALE, strobes and
// byte pins. Purely combinational; clk and rst_n feed the assertions only.
module ebus_pinmux
    import ebus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_i,
    input  bus_cfg_t          cfg_q_i,
    input  logic              live_ale_hi_i,
    input  logic              we_q_i,
    input  logic [ADDR_W-1:0] addr_q_i,
    input  logic [DATA_W-1:0] wdata_q_i,
    output logic [DATA_W-1:0] pa_out_o,
    output logic              pa_oe_o,
    output logic [DATA_W-1:0] pb_out_o,
    output logic [DATA_W-1:0] pc_out_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              pin_lo_o,
    output logic              pin_hi_o
);
    logic active;
    logic ale_act;
    logic rd_act;
    logic wr_act;

    // Port values and output enable per phase and bus mode.
    always_comb begin
        active   = (phase_i == PH_ADDR) || (phase_i == PH_GAP) || (phase_i == PH_STRB);
        pa_out_o = '0;
        pa_oe_o  = 1'b0;
        pb_out_o = '0;
        pc_out_o = '0;
        ale_act  = 1'b0;
        if (active) begin
            if (cfg_q_i.mux) begin
                pc_out_o = addr_q_i[3*DATA_W-1:2*DATA_W];
                if (phase_i != PH_STRB) begin
                    pa_out_o = addr_q_i[DATA_W-1:0];
                    pb_out_o = addr_q_i[2*DATA_W-1:DATA_W];
                    pa_oe_o  = 1'b1;
                    ale_act  = (phase_i == PH_ADDR);
                end else if (we_q_i) begin
                    pa_out_o = wdata_q_i;
                    pa_oe_o  = 1'b1;
                end
            end else begin
                pc_out_o = addr_q_i[2*DATA_W-1:DATA_W];
                pb_out_o = addr_q_i[DATA_W-1:0];
                if (we_q_i) begin
                    pa_out_o = wdata_q_i;
                    pa_oe_o  = 1'b1;
                end
            end
        end
    end

    // Strobes, ALE level and byte pin function.
    always_comb begin
        rd_act   = (phase_i == PH_STRB) && !we_q_i;
        wr_act   = (phase_i == PH_STRB) && we_q_i;
        rd_n_o   = !rd_act;
        wr_n_o   = !wr_act;
        if (active) ale_o = ale_act ? cfg_q_i.ale_hi : !cfg_q_i.ale_hi;
        else        ale_o = !live_ale_hi_i;
        pin_lo_o = cfg_q_i.pin_be ? !active : !wr_act;
        pin_hi_o = 1'b1;
    end

    AST_PB_ZERO_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o && cfg_q_i.mux) |-> (pb_out_o == '0)); // R2
    AST_PA_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !pa_oe_o); // R2
    AST_ALE_OFF_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> (ale_o == !cfg_q_i.ale_hi)); // R3
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R4
endmodule

// File: rtl/ebus_clkgen.sv
// Bus clock output: off (held low), core rate, or half rate from a toggle
// register. Assumes the mode input is static or changed only while idle.
module ebus_clkgen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output logic       bclk_o
);
    logic div_q;

    // Half-rate toggle, held low when half rate is not selected.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= 1'b0;
        else if (mode_i[1]) div_q <= !div_q;
        else                div_q <= 1'b0;
    end

    assign bclk_o = (mode_i == 2'd1) ? clk : (mode_i[1] ? div_q : 1'b0);

    AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_i[1] && $past(mode_i[1])) |-> (div_q != $past(div_q))); // R10
endmodule

// File: rtl/ebus_ctrl.sv
// External memory bus controller top: joins the sequencer, pin decoder
// and bus clock generator. One access in flight at a time; assumes all
// inputs are synchronous to clk.
module ebus_ctrl
    import ebus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_rdy,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_mux,
    input  logic              cfg_ale_hi,
    input  logic              cfg_pin_be,
    input  logic [ACNT_W-1:0] cfg_addr_clks,
    input  logic [SCNT_W-1:0] cfg_strb_clks,
    input  logic [1:0]        cfg_bclk_mode,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              pin_lo,
    output logic              pin_hi,
    output logic              bclk
);
    bus_cfg_t          cfg_live;
    bus_cfg_t          cfg_q;
    phase_e            phase;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Pack the loose configuration pins into the shared record.
    always_comb begin
        cfg_live.mux       = cfg_mux;
        cfg_live.ale_hi    = cfg_ale_hi;
        cfg_live.pin_be    = cfg_pin_be;
        cfg_live.addr_clks = cfg_addr_clks;
        cfg_live.strb_clks = cfg_strb_clks;
    end

    ebus_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .req_we_i   (req_we),
        .req_addr_i (req_addr),
        .req_wdata_i(req_wdata),
        .cfg_i      (cfg_live),
        .wait_n_i   (wait_n),
        .pa_in_i    (pa_in),
        .req_rdy_o  (req_rdy),
        .ack_o      (ack),
        .rd_data_o  (rd_data),
        .phase_o    (phase),
        .cfg_q_o    (cfg_q),
        .we_q_o     (we_q),
        .addr_q_o   (addr_q),
        .wdata_q_o  (wdata_q)
    );

    ebus_pinmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pinmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .cfg_q_i      (cfg_q),
        .live_ale_hi_i(cfg_ale_hi),
        .we_q_i       (we_q),
        .addr_q_i     (addr_q),
        .wdata_q_i    (wdata_q),
        .pa_out_o     (pa_out),
        .pa_oe_o      (pa_oe),
        .pb_out_o     (pb_out),
        .pc_out_o     (pc_out),
        .ale_o        (ale),
        .rd_n_o       (rd_n),
        .wr_n_o       (wr_n),
        .pin_lo_o     (pin_lo),
        .pin_hi_o     (pin_hi)
    );

    ebus_clkgen u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .mode_i(cfg_bclk_mode),
        .bclk_o(bclk)
    );
endmodule

// File: tb/sim_ebus_ctrl.sv
module sim_ebus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_rdy, ack;
    logic [7:0]  rd_data;
    logic        cfg_mux = 1'b1, cfg_ale_hi = 1'b1, cfg_pin_be = 1'b0;
    logic [1:0]  cfg_addr_clks = '0;
    logic [2:0]  cfg_strb_clks = '0;
    logic [1:0]  cfg_bclk_mode = '0;
    logic        wait_n = 1'b1;
    logic [7:0]  pa_in = '0;
    logic [7:0]  pa_out, pb_out, pc_out;
    logic        pa_oe, ale, rd_n, wr_n, pin_lo, pin_hi, bclk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ebus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_rdy(req_rdy), .ack(ack), .rd_data(rd_data),
        .cfg_mux(cfg_mux), .cfg_ale_hi(cfg_ale_hi), .cfg_pin_be(cfg_pin_be),
        .cfg_addr_clks(cfg_addr_clks), .cfg_strb_clks(cfg_strb_clks),
        .cfg_bclk_mode(cfg_bclk_mode), .wait_n(wait_n), .pa_in(pa_in),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pc_out(pc_out),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .pin_lo(pin_lo), .pin_hi(pin_hi),
        .bclk(bclk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected idle pins (R11, R3 with live polarity, R7).
    task automatic chk_idle();
        chk("R11 pa_out", 32'(pa_out), 0);
        chk("R11 pa_oe",  32'(pa_oe), 0);
        chk("R11 pb_out", 32'(pb_out), 0);
        chk("R11 pc_out", 32'(pc_out), 0);
        chk("R11 rd_n",   32'(rd_n), 1);
        chk("R11 wr_n",   32'(wr_n), 1);
        chk("R11 pin_lo", 32'(pin_lo), 1);
        chk("R11 pin_hi", 32'(pin_hi), 1);
        chk("R3 ale idle", 32'(ale), 32'(!cfg_ale_hi));
        chk("R7 req_rdy", 32'(req_rdy), 1);
    endtask

    // One access, driven from an idle negedge; checks every pin each clock.
    task automatic txn(input bit we, input logic [23:0] addr, input logic [7:0] wd,
                       input logic [7:0] rdv, input bit m, input bit ah, input bit be,
                       input int ac, input int sc, input int lw);
        int a_len, t_len, last;
        a_len = ac + 1;
        t_len = (lw + 1 > sc + 1) ? lw + 1 : sc + 1;
        last  = a_len + 2 + t_len;
        cfg_mux = m; cfg_ale_hi = ah; cfg_pin_be = be;
        cfg_addr_clks = 2'(ac); cfg_strb_clks = 3'(sc);
        req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        wait_n = 1'b1; pa_in = 8'($urandom);
        chk("R7 ready before accept", 32'(req_rdy), 1);
        for (int i = 0; i <= last; i++) begin
            int ph, j;
            logic act;
            logic [7:0] e_pa, e_pb, e_pc;
            logic e_oe, e_ale, e_rd, e_wr, e_lo;
            string tp;
            @(posedge clk);
            @(negedge clk);
            if (i < a_len) ph = 0;
            else if (i == a_len) ph = 1;
            else if (i < a_len + 1 + t_len) ph = 2;
            else if (i == a_len + 1 + t_len) ph = 3;
            else ph = 4;
            j = i - (a_len + 1);
            act = (ph <= 2);
            if (ph == 4) begin
                chk_idle();
            end else begin
                e_pa = 0; e_pb = 0; e_pc = 0; e_oe = 0;
                if (act) begin
                    if (m) begin
                        e_pc = addr[23:16];
                        if (ph < 2) begin e_pa = addr[7:0]; e_pb = addr[15:8]; e_oe = 1; end
                        else if (we) begin e_pa = wd; e_oe = 1; end
                    end else begin
                        e_pc = addr[15:8]; e_pb = addr[7:0];
                        if (we) begin e_pa = wd; e_oe = 1; end
                    end
                end
                if (!act) tp = "R11";
                else if (!m) tp = "R8";
                else if (ph < 2) tp = "R1";
                else tp = "R2";
                if (act) e_ale = (m && ph == 0) ? ah : !ah;
                else     e_ale = !cfg_ale_hi;
                e_rd = !(ph == 2 && !we);
                e_wr = !(ph == 2 && we);
                e_lo = be ? !act : e_wr;
                chk({tp, " pa_out"}, 32'(pa_out), 32'(e_pa));
                chk({tp, " pa_oe"},  32'(pa_oe),  32'(e_oe));
                chk({tp, " pb_out"}, 32'(pb_out), 32'(e_pb));
                chk({tp, " pc_out"}, 32'(pc_out), 32'(e_pc));
                chk(act ? "R3 R12 ale" : "R3 ale", 32'(ale), 32'(e_ale));
                chk(lw > 0 ? "R5 rd_n" : "R4 rd_n", 32'(rd_n), 32'(e_rd));
                chk(lw > 0 ? "R5 wr_n" : "R4 wr_n", 32'(wr_n), 32'(e_wr));
                chk("R9 pin_lo", 32'(pin_lo), 32'(e_lo));
                chk("R9 pin_hi", 32'(pin_hi), 1);
                chk("R6 ack", 32'(ack), 32'(ph == 3));
                chk("R7 req_rdy busy", 32'(req_rdy), 0);
                if (ph == 3 && !we) chk("R6 rd_data", 32'(rd_data), 32'(rdv));
            end
            // Inputs for the next sampled edge; settings scrambled while busy (R12).
            if (i < a_len + 1 + t_len) begin
                req = 1'($urandom); req_addr = 24'($urandom); req_we = 1'($urandom);
                cfg_mux = 1'($urandom); cfg_ale_hi = 1'($urandom); cfg_pin_be = 1'($urandom);
                cfg_addr_clks = 2'($urandom); cfg_strb_clks = 3'($urandom);
            end else begin
                req = 1'b0;
            end
            if (j >= 0 && j < t_len) wait_n = !(j < lw);
            else wait_n = 1'($urandom);
            pa_in = (j == t_len - 1) ? rdv : 8'($urandom);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL R7 watchdog act=hung exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle();                         // reset state, R11
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle();
        // Directed corners: shortest and longest phases, both polarities.
        txn(1, 24'hA1B2C3, 8'h5A, 8'h00, 1, 1, 0, 0, 0, 0);   // R1 R2 minimum
        txn(0, 24'h0F1E2D, 8'h00, 8'hC7, 1, 0, 0, 3, 7, 0);   // R6 maximum, ALE low
        txn(0, 24'h123456, 8'h00, 8'h3C, 1, 1, 1, 1, 1, 10);  // R5 long wait, R9 enables
        txn(1, 24'hFEDCBA, 8'h99, 8'h00, 1, 0, 1, 2, 0, 3);   // R5 wait on write
        txn(1, 24'h00BEEF, 8'h81, 8'h00, 0, 1, 0, 1, 2, 0);   // R8 write
        txn(0, 24'h77CAFE, 8'h00, 8'hE4, 0, 0, 1, 0, 3, 2);   // R8 read
        // Constrained random mix.
        for (int k = 0; k < 150; k++) begin
            int lw;
            lw = ($urandom % 4 == 0) ? int'($urandom % 12) : 0;
            txn(1'($urandom), 24'($urandom), 8'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 4), int'($urandom % 8), lw);
        end
        // Bus clock modes, R10.
        cfg_bclk_mode = 2'd0;
        repeat (4) begin
            @(posedge clk); #5 chk("R10 off high", 32'(bclk), 0);
            @(negedge clk); chk("R10 off low", 32'(bclk), 0);
        end
        cfg_bclk_mode = 2'd1;
        repeat (4) begin
            @(posedge clk); #5 chk("R10 full high", 32'(bclk), 1);
            @(negedge clk); chk("R10 full low", 32'(bclk), 0);
        end
        cfg_bclk_mode = 2'd2;
        @(negedge clk);
        begin
            logic prev;
            prev = bclk;
            repeat (6) begin
                @(negedge clk);
                chk("R10 half toggle", 32'(bclk), 32'(!prev));
                prev = bclk;
            end
        end
        cfg_bclk_mode = 2'd0;
        @(negedge clk);
        chk_idle();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule